// File: doc/BRIEF.md
# PPS Phase Error Comparator

This block measures the phase of a once-per-second reference pulse against a local oscillator. A counter driven by the local clock runs freely and is never cleared by the pulse. Each rising edge of the asynchronous pulse input is synchronised and converted into a single-cycle strobe, and the counter value is captured at that strobe. The block keeps a running prediction of the count at which the next pulse should land. For each pulse it reports the signed difference between the prediction and the capture. Because the prediction advances by one nominal second per pulse, no matter when the pulse actually came, any fractional frequency error in the oscillator builds up into a growing phase offset. A downstream loop filter can then steer on phase rather than on period.

The counter range can be a power of two (`MODULUS` = 0, range 2^`CNT_W`), in which case the prediction advances by `PERIOD` modulo the range on each pulse. It can instead be an arbitrary modulus. When the modulus divides `PERIOD`, the prediction stays constant and can be preset to mid-range. If the pulse stops arriving, a missing-pulse strobe fires and the prediction keeps advancing once per nominal second. The result interface is a plain strobe with no ready input, and there is no back-pressure. A result cannot be delayed, so the consumer must take `err_o` in the cycle `err_valid_o` is high; `err_o` then holds until the next report.

Top module: `pps_phase_cmp`

## Requirements
- R1: The timebase counter advances by one on every clock and wraps from range-1 to 0, where range is 2^`CNT_W` when `MODULUS` is 0 and `MODULUS` otherwise. The pulse input never alters the counter.
- R2: If the pulse input is first seen high at rising clock edge n (edges counted from 1 after reset release), the timestamp is the counter value produced by edge n+1, that is (n+1) mod range. It is taken at edge n+2.
- R3: Exactly one timestamp is taken per low-to-high transition of the pulse input. The input staying high produces no further report.
- R4: `err_o` is (expected − timestamp) mod range, folded to a signed value. Residues greater than (range−1)/2 are reported as residue − range. `err_o` is two's complement, `CNT_W`+1 bits wide.
- R5: The expected arrival starts at `EXP_INIT`. It advances by `PERIOD` mod range after each reported pulse and after each missing-pulse event.
- R6: In modulus mode with `MODULUS` dividing `PERIOD`, the expected arrival stays at `EXP_INIT` for every pulse.
- R7: `err_valid_o` is high for exactly one cycle, following edge n+3. `err_o` is updated at that same edge and holds until the next report.
- R8: If 2.5×`PERIOD` clock edges pass after a capture edge (or after reset) with no capture, `miss_o` is high for one cycle following that edge. It then repeats every `PERIOD` edges while the input stays silent.
- R9: While reset is high, `err_o` is 0, `err_valid_o` and `miss_o` are low, the counter is 0 and the expected arrival returns to `EXP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oscillator clock (nominally 10 MHz) |
| rst_i | input | 1 | Synchronous active-high reset |
| pps_i | input | 1 | Asynchronous once-per-second reference pulse |
| err_o | output | CNT_W+1 | Signed phase error, expected minus actual |
| err_valid_o | output | 1 | One-cycle strobe marking a new `err_o` |
| miss_o | output | 1 | One-cycle strobe for a pulse that failed to arrive |

## Verification
A pulse driven between clock edges is first seen at edge n. The timestamp is the counter value after edge n+1, and the report is visible after edge n+3, so the bench samples `err_valid_o` and `err_o` at the falling edge after n+3. It also checks that the strobe is absent one cycle earlier and one cycle later. The missing-pulse strobe is due 2.5×`PERIOD` edges after the capture edge n+2, and again `PERIOD` edges later. The bench waits on its own edge count to land exactly on those cycles and on the cycle before each. Expected counts and errors come from a model built on the edge count since reset, not from the design.

// File: rtl/pps_pkg.sv
package pps_pkg;

  // Counter range: power of two when modulus is zero, else the modulus.
  function automatic logic [63:0] range_of(input int unsigned cnt_w,
                                           input int unsigned modulus);
    if (modulus == 0) return 64'd1 << cnt_w;
    return 64'(modulus);
  endfunction

  // a + b reduced into [0, r), both operands already below r.
  function automatic logic [63:0] mod_add(input logic [63:0] a,
                                          input logic [63:0] b,
                                          input logic [63:0] r);
    logic [63:0] s;
    s = a + b;
    if (s >= r) s = s - r;
    return s;
  endfunction

  // a - b reduced into [0, r), both operands already below r.
  function automatic logic [63:0] mod_sub(input logic [63:0] a,
                                          input logic [63:0] b,
                                          input logic [63:0] r);
    if (a >= b) return a - b;
    return a + r - b;
  endfunction

  // Residues in the upper half of the range become negative (two's complement).
  function automatic logic [63:0] fold_signed(input logic [63:0] d,
                                              input logic [63:0] r);
    if (d > ((r - 64'd1) >> 1)) return d - r;
    return d;
  endfunction

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pps_i,
  output logic rise_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  // Synchroniser stages followed by one history flop for edge detection.
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= {sh_q[SH_W-2:0], pps_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R3: a held-high input yields one strobe only
  a_r3_single_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pps_timebase.sv
module pps_timebase #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MODULUS = 0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  generate
    if (MODULUS == 0) begin : g_bin
      always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_mod
      localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);
      always_ff @(posedge clk_i) begin
        if (rst_i)              cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      // R6: count never leaves the modulus range
      a_r6_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);
    end
  endgenerate

  assign cnt_o = cnt_q;

  // R1: every nonzero value is the previous one plus one
  a_r1_advance: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pps_err_track.sv
module pps_err_track
  import pps_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned MODULUS  = 0,
  parameter int unsigned PERIOD   = 10_000_000,
  parameter int unsigned EXP_INIT = 0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W:0]   err_o,
  output logic             valid_o,
  output logic             miss_o
);
  localparam int unsigned      ERR_W      = CNT_W + 1;
  localparam logic [63:0]      RANGE      = range_of(CNT_W, MODULUS);
  localparam logic [63:0]      STEP       = 64'(PERIOD) % RANGE;
  localparam longint unsigned  MISS_CYC   = 2 * longint'(PERIOD) + longint'(PERIOD) / 2;
  localparam int unsigned      TMR_W      = $clog2(MISS_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST   = TMR_W'(MISS_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_RELOAD = TMR_W'(MISS_CYC - longint'(PERIOD));
  localparam logic [CNT_W-1:0] EXP_RST    = CNT_W'(EXP_INIT);

  logic [CNT_W-1:0] cap_q, exp_q;
  logic             pend_q;
  logic [TMR_W-1:0] tmr_q;
  logic [ERR_W-1:0] err_q;
  logic             valid_q, miss_q;

  logic [63:0] diff_w, fold_w, exp_w;
  logic        timeout_w;

  always_comb begin
    diff_w    = mod_sub(64'(exp_q), 64'(cap_q), RANGE);
    fold_w    = fold_signed(diff_w, RANGE);
    exp_w     = mod_add(64'(exp_q), STEP, RANGE);
    timeout_w = !rise_i && (tmr_q == TMR_LAST);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cap_q   <= '0;
      exp_q   <= EXP_RST;
      pend_q  <= 1'b0;
      tmr_q   <= '0;
      err_q   <= '0;
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      pend_q  <= rise_i;
      valid_q <= pend_q;
      miss_q  <= timeout_w;
      if (rise_i) begin
        cap_q <= cnt_i;
        tmr_q <= '0;
      end else if (timeout_w) begin
        tmr_q <= TMR_RELOAD;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
      if (pend_q) err_q <= ERR_W'(fold_w);
      if (pend_q || timeout_w) exp_q <= CNT_W'(exp_w);
    end
  end

  assign err_o   = err_q;
  assign valid_o = valid_q;
  assign miss_o  = miss_q;

  // R7: the report strobe lasts one cycle
  a_r7_single_valid: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  // R7: a capture strobe is reported two edges later
  a_r7_after_capture: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_i |=> ##1 valid_o);

  // R7: the error word only moves together with a report
  a_r7_err_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !valid_o) |-> $stable(err_o));

  // R8: the missing strobe lasts one cycle
  a_r8_single_miss: assert property (@(posedge clk_i) disable iff (rst_i)
    miss_o |=> !miss_o);

  // R8: a capture restarts the silence window
  a_r8_quiet_after_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_i |=> !miss_o);

  // R5: the prediction moves only on a report or a missing event
  a_r5_expected_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !valid_o && !miss_o) |-> $stable(exp_q));

endmodule

// File: rtl/pps_phase_cmp.sv
module pps_phase_cmp #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned MODULUS     = 0,
  parameter int unsigned PERIOD      = 10_000_000,
  parameter int unsigned EXP_INIT    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           pps_i,
  output logic [CNT_W:0] err_o,
  output logic           err_valid_o,
  output logic           miss_o
);
  logic             rise_w;
  logic [CNT_W-1:0] cnt_w;

  pps_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .pps_i (pps_i),
    .rise_o(rise_w)
  );

  pps_timebase #(
    .CNT_W  (CNT_W),
    .MODULUS(MODULUS)
  ) tb_i (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .cnt_o(cnt_w)
  );

  pps_err_track #(
    .CNT_W   (CNT_W),
    .MODULUS (MODULUS),
    .PERIOD  (PERIOD),
    .EXP_INIT(EXP_INIT)
  ) trk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .rise_i (rise_w),
    .cnt_i  (cnt_w),
    .err_o  (err_o),
    .valid_o(err_valid_o),
    .miss_o (miss_o)
  );

endmodule

// File: tb/pps_phase_cmp_tb_top.sv
module pps_phase_cmp_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 100;

  localparam int A_W    = 10;
  localparam int A_R    = 1 << A_W;
  localparam int A_PER  = 1500;
  localparam int A_STEP = A_PER % A_R;
  localparam int A_MISS = 2 * A_PER + A_PER / 2;

  localparam int B_W    = 8;
  localparam int B_MOD  = 200;
  localparam int B_PER  = 1600;
  localparam int B_INIT = 100;
  localparam int B_MISS = 2 * B_PER + B_PER / 2;

  localparam int NVEC = 10;
  localparam int LEADS [NVEC] = '{1476, 1476, 1456, 1506, 1471, 1477, 1436, 1520, 1475, 1496};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pps = 1'b0;
  logic [A_W:0] a_err;
  logic [B_W:0] b_err;
  logic a_val, a_miss, b_val, b_miss;

  pps_phase_cmp #(.CNT_W(A_W), .MODULUS(0), .PERIOD(A_PER), .EXP_INIT(0)) dut_i (
    .clk_i(clk), .rst_i(rst), .pps_i(pps),
    .err_o(a_err), .err_valid_o(a_val), .miss_o(a_miss));

  pps_phase_cmp #(.CNT_W(B_W), .MODULUS(B_MOD), .PERIOD(B_PER), .EXP_INIT(B_INIT)) dut_mod_i (
    .clk_i(clk), .rst_i(rst), .pps_i(pps),
    .err_o(b_err), .err_valid_o(b_val), .miss_o(b_miss));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  longint a_exp = 0;
  longint a_seen;
  int last_t;

  function automatic longint fold(input longint d, input longint r);
    longint m;
    m = d % r;
    if (m < 0) m = m + r;
    if (m > (r - 1) / 2) m = m - r;
    return m;
  endfunction

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // Rise after lead cycles, then 24 cycles of observation; low again at 20.
  task automatic pulse(input int lead, input string req);
    longint a_e, b_e;
    repeat (lead) @(negedge clk);
    pps = 1'b1;
    last_t = cyc;
    a_e = fold(a_exp - ((last_t + 2) % A_R), A_R);
    b_e = fold(B_INIT - ((last_t + 2) % B_MOD), B_MOD);
    a_exp = (a_exp + A_STEP) % A_R;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (i == 3) check_eq("R7", "valid early", longint'(a_val), 0);
      if (i == 4) begin
        check_eq("R7", "valid due", longint'(a_val), 1);
        check_eq(req, "error word", longint'($signed(a_err)), a_e);
        check_eq("R6", "modulo valid due", longint'(b_val), 1);
        check_eq("R6 R4", "modulo error word", longint'($signed(b_err)), b_e);
        a_seen = longint'($signed(a_err));
      end
      if (i == 5) begin
        check_eq("R7", "valid one cycle", longint'(a_val), 0);
        check_eq("R7", "modulo valid one cycle", longint'(b_val), 0);
      end
      if (i == 12) begin
        check_eq("R3", "no repeat while held high", longint'(a_val), 0);
        check_eq("R7", "error held", longint'($signed(a_err)), a_e);
      end
      if (i == 20) pps = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int lead;
    int wrap_tgt [3];
    wrap_tgt = '{511, -512, 0};

    repeat (5) @(negedge clk);
    check_eq("R9", "reset err", longint'(a_err), 0);
    check_eq("R9", "reset valid", longint'(a_val), 0);
    check_eq("R9", "reset miss", longint'(a_miss), 0);
    check_eq("R9", "reset modulo err", longint'(b_err), 0);
    rst = 1'b0;
    a_exp = 0;
    repeat (100) @(negedge clk);

    // Vector table walk: varying spacing makes phase drift up and down.
    for (int v = 0; v < NVEC; v++) pulse(LEADS[v], "R1 R2 R4 R5");

    // R4 fold corners: last positive, first negative, zero.
    for (int k = 0; k < 3; k++) begin
      lead = int'(((a_exp - wrap_tgt[k] - 2 - cyc) % A_R + A_R) % A_R);
      if (lead < 100) lead = lead + A_R;
      pulse(lead, "R4 R2");
      check_eq("R4", "fold corner", a_seen, wrap_tgt[k]);
    end

    // R8: silence; first and repeated missing strobes.
    while (cyc < last_t + 3 + A_MISS - 1) @(negedge clk);
    check_eq("R8", "no miss before window", longint'(a_miss), 0);
    @(negedge clk);
    check_eq("R8", "miss due", longint'(a_miss), 1);
    a_exp = (a_exp + A_STEP) % A_R;
    @(negedge clk);
    check_eq("R8", "miss one cycle", longint'(a_miss), 0);
    while (cyc < last_t + 3 + B_MISS - 1) @(negedge clk);
    check_eq("R8", "modulo no miss before window", longint'(b_miss), 0);
    @(negedge clk);
    check_eq("R8", "modulo miss due", longint'(b_miss), 1);
    while (cyc < last_t + 3 + A_MISS + A_PER - 1) @(negedge clk);
    check_eq("R8", "no early repeat", longint'(a_miss), 0);
    @(negedge clk);
    check_eq("R8", "repeat miss due", longint'(a_miss), 1);
    a_exp = (a_exp + A_STEP) % A_R;
    pulse(200, "R8 R5");

    // R9: reset mid-run clears outputs and the prediction.
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R9", "mid reset err", longint'(a_err), 0);
    check_eq("R9", "mid reset valid", longint'(a_val), 0);
    check_eq("R9", "mid reset miss", longint'(a_miss), 0);
    rst = 1'b0;
    a_exp = 0;
    repeat (30) @(negedge clk);
    pulse(10, "R9 R1 R4");

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule